// File: doc/BRIEF.md
# Driver Impedance Calibration Sequencer

This block keeps the strength code of a set of output drivers tracking an external impedance comparison. A sensing circuit outside the block reports, as a two-bit result, whether the drivers should become stronger, weaker or stay as they are. The block samples that result once per evaluation interval of `EVAL_PERIOD` clocks and moves an internal target code by no more than one step each time. The target saturates at both ends of the code range.

The code that actually reaches the drivers is a separate register. It is loaded from the target only in clock cycles where the output pins are reported as high impedance. Write and deselect cycles put the pins in that state, so on a normal bus they open the update windows. While the pins are driving, a new target waits, and the first high-Z cycle after it applies it.

After reset the block counts `SETTLE_CYCLES` clocks. Once that count has completed, the next transition of the pins from driving to high-Z raises a ready flag. The flag means the driver impedance is now guaranteed. Only reset clears the flag.

Top module: `drv_imp_cal`

## Requirements
- R1: While reset is active, and after it is released, `drv_code_o` equals `RESET_CODE` (16 by default) and `cal_ready_o` is 0.
- R2: The comparator input `cmp_i` is encoded as follows: 2'b01 requests a stronger driver (target code +1), 2'b10 requests a weaker driver (target code −1), and 2'b00 and 2'b11 both mean "equal" and leave the target unchanged.
- R3: The target code is evaluated only on the `EVAL_PERIOD`-th clock edge after reset and on every `EVAL_PERIOD`-th edge after that. At any other edge the target does not change, and one evaluation changes it by at most one step.
- R4: The target code saturates at 0 and at 2^CODE_W−1 (31 by default) and never wraps.
- R5: `drv_code_o` changes only at a clock edge where `hiz_i` was sampled high (or at reset). At such an edge it takes the current target code.
- R6: A target code produced while `hiz_i` is low is held. It is applied at the first clock edge at which `hiz_i` is sampled high.
- R7: `cal_ready_o` rises only at an edge where `hiz_i` is sampled high after having been low at the previous edge, and only once at least `SETTLE_CYCLES` edges have passed since reset. A driving-to-high-Z transition before that point, or high-Z held with no new transition, does not set it.
- R8: Once set, `cal_ready_o` stays high until reset, whatever `hiz_i` does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmp_i | input | 2 | Comparator result: 01 stronger, 10 weaker, 00/11 equal |
| hiz_i | input | 1 | High when the output pins are in high impedance |
| drv_code_o | output | CODE_W | Strength code applied to the drivers |
| cal_ready_o | output | 1 | Impedance guaranteed after settling and a high-Z transition |

## Verification
The bench builds the block with `EVAL_PERIOD` = 8 and `SETTLE_CYCLES` = 100, and keeps the 5-bit code and a reset code of 16. The short interval lets a few hundred cycles walk the code into both saturation limits. It also places the settling boundary close enough to test a high-Z transition on each side of it. The interval edge itself is probed one cycle before and one cycle after the first evaluation.

// File: rtl/drv_imp_pkg.sv
// Shared definitions for the driver impedance calibration sequencer.
// Assumes a two-bit comparator result; both non-directional codes mean "equal".
package drv_imp_pkg;
    typedef enum logic [1:0] {
        CMP_EQUAL  = 2'b00,
        CMP_UP     = 2'b01,
        CMP_DOWN   = 2'b10,
        CMP_EQUAL2 = 2'b11
    } cmp_e;
endpackage

// File: rtl/imp_eval_timer.sv
// Evaluation interval timer: raises tick_o for one cycle out of every PERIOD,
// the first time in the cycle before the PERIOD-th edge after reset.
// Assumes PERIOD >= 2.
module imp_eval_timer #(
    parameter int PERIOD = 64
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int  CNT_W  = $clog2(PERIOD);
    localparam bit  IS_POW2 = (PERIOD == (1 << CNT_W));
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

    logic [CNT_W-1:0] cnt_q;

    generate
        if (IS_POW2) begin : g_pow2
            // Free-running wrap counter when the period is a power of two
            always_ff @(posedge clk) begin
                if (!rst_n) cnt_q <= '0;
                else        cnt_q <= cnt_q + CNT_W'(1);
            end
        end else begin : g_cmp
            // Compare-and-clear counter for any other period
            always_ff @(posedge clk) begin
                if (!rst_n)             cnt_q <= '0;
                else if (cnt_q == LAST) cnt_q <= '0;
                else                    cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    endgenerate

    assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/imp_code_stepper.sv
// Target code stepper: on each tick moves the target one step in the direction
// the comparator asks for, saturating at both ends.
// Assumes cmp_i is stable around the tick cycle.
module imp_code_stepper
    import drv_imp_pkg::*;
#(
    parameter int CODE_W     = 5,
    parameter int RESET_CODE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic [1:0]        cmp_i,
    output logic [CODE_W-1:0] code_o
);
    localparam logic [CODE_W-1:0] MAX_CODE = {CODE_W{1'b1}};
    localparam logic [CODE_W-1:0] MIN_CODE = '0;

    logic [CODE_W-1:0] code_q;
    cmp_e              cmp;

    assign cmp = cmp_e'(cmp_i);

    // Saturating one-step update of the target, once per evaluation tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= CODE_W'(RESET_CODE);
        end else if (tick_i) begin
            case (cmp)
                CMP_UP:   if (code_q != MAX_CODE) code_q <= code_q + CODE_W'(1);
                CMP_DOWN: if (code_q != MIN_CODE) code_q <= code_q - CODE_W'(1);
                default:  code_q <= code_q;
            endcase
        end
    end

    assign code_o = code_q;
endmodule

// File: rtl/imp_apply_gate.sv
// Apply gate: copies the pending target to the driver code only in cycles where
// the pins are high impedance; otherwise the driver code is held.
// Assumes hiz_i is synchronous to clk.
module imp_apply_gate #(
    parameter int CODE_W     = 5,
    parameter int RESET_CODE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hiz_i,
    input  logic [CODE_W-1:0] tgt_i,
    output logic [CODE_W-1:0] code_o
);
    logic [CODE_W-1:0] code_q;

    // Load the driver code during a high-Z window only
    always_ff @(posedge clk) begin
        if (!rst_n)     code_q <= CODE_W'(RESET_CODE);
        else if (hiz_i) code_q <= tgt_i;
    end

    assign code_o = code_q;
endmodule

// File: rtl/imp_settle_tracker.sv
// Settle tracker: counts SETTLE clocks after reset, then raises ready on the next
// driving-to-high-Z transition and keeps it until reset.
// Assumes the pins are high-Z during reset (previous-state flop resets high).
module imp_settle_tracker #(
    parameter int SETTLE = 2080
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hiz_i,
    output logic ready_o
);
    localparam int CNT_W = $clog2(SETTLE + 1);
    localparam logic [CNT_W-1:0] DONE_VAL = CNT_W'(SETTLE);

    logic [CNT_W-1:0] cnt_q;
    logic             hiz_q;
    logic             ready_q;
    logic             done;
    logic             hiz_rise;

    assign done     = (cnt_q == DONE_VAL);
    assign hiz_rise = hiz_i && !hiz_q;

    // Saturating settle counter
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt_q <= '0;
        else if (!done) cnt_q <= cnt_q + CNT_W'(1);
    end

    // Previous high-Z state for transition detection
    always_ff @(posedge clk) begin
        if (!rst_n) hiz_q <= 1'b1;
        else        hiz_q <= hiz_i;
    end

    // Sticky ready flag
    always_ff @(posedge clk) begin
        if (!rst_n)                ready_q <= 1'b0;
        else if (done && hiz_rise) ready_q <= 1'b1;
    end

    assign ready_o = ready_q;
endmodule

// File: rtl/drv_imp_cal.sv
// Driver impedance calibration sequencer top: interval timer, target stepper,
// high-Z apply gate and settle tracker.
// Assumes cmp_i and hiz_i are synchronous to clk.
module drv_imp_cal #(
    parameter int CODE_W        = 5,
    parameter int EVAL_PERIOD   = 64,
    parameter int SETTLE_CYCLES = 2080,
    parameter int RESET_CODE    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cmp_i,
    input  logic              hiz_i,
    output logic [CODE_W-1:0] drv_code_o,
    output logic              cal_ready_o
);
    logic              eval_tick;
    logic [CODE_W-1:0] tgt_code;

    imp_eval_timer #(.PERIOD(EVAL_PERIOD)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (eval_tick)
    );

    imp_code_stepper #(.CODE_W(CODE_W), .RESET_CODE(RESET_CODE)) u_stepper (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (eval_tick),
        .cmp_i  (cmp_i),
        .code_o (tgt_code)
    );

    imp_apply_gate #(.CODE_W(CODE_W), .RESET_CODE(RESET_CODE)) u_gate (
        .clk    (clk),
        .rst_n  (rst_n),
        .hiz_i  (hiz_i),
        .tgt_i  (tgt_code),
        .code_o (drv_code_o)
    );

    imp_settle_tracker #(.SETTLE(SETTLE_CYCLES)) u_settle (
        .clk     (clk),
        .rst_n   (rst_n),
        .hiz_i   (hiz_i),
        .ready_o (cal_ready_o)
    );
endmodule

// File: rtl/drv_imp_cal_chk.sv
// Property checker for drv_imp_cal, attached by bind below.
// Assumes synchronous active-low reset.
module drv_imp_cal_chk #(
    parameter int CODE_W        = 5,
    parameter int SETTLE_CYCLES = 2080
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hiz_i,
    input logic              eval_tick,
    input logic [CODE_W-1:0] tgt_code,
    input logic [CODE_W-1:0] drv_code_o,
    input logic              cal_ready_o
);
    localparam int CW = $clog2(SETTLE_CYCLES + 2);
    localparam logic [CW-1:0] SAT = CW'(SETTLE_CYCLES + 1);

    logic [CW-1:0] since_rst;

    // Edges since reset, saturating just past the settle limit
    always_ff @(posedge clk) begin
        if (!rst_n)               since_rst <= '0;
        else if (since_rst != SAT) since_rst <= since_rst + CW'(1);
    end

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((int'(tgt_code) - int'($past(tgt_code)) <= 1) &&
                          (int'(tgt_code) - int'($past(tgt_code)) >= -1))); // R4
    AST_TGT_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(eval_tick) |-> $stable(tgt_code)); // R3
    AST_HOLD_LOWZ: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(hiz_i) |-> $stable(drv_code_o)); // R5
    AST_APPLY_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(hiz_i) |-> drv_code_o == $past(tgt_code)); // R6
    AST_READY_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $rose(cal_ready_o) |-> $past(hiz_i) && !$past(hiz_i, 2)); // R7
    AST_READY_SETTLED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cal_ready_o) |-> int'(since_rst) > SETTLE_CYCLES); // R7
    AST_READY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        cal_ready_o |=> cal_ready_o); // R8
endmodule

bind drv_imp_cal drv_imp_cal_chk #(
    .CODE_W        (CODE_W),
    .SETTLE_CYCLES (SETTLE_CYCLES)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .hiz_i       (hiz_i),
    .eval_tick   (eval_tick),
    .tgt_code    (tgt_code),
    .drv_code_o  (drv_code_o),
    .cal_ready_o (cal_ready_o)
);

// File: tb/drv_imp_cal_bench.sv
// Self-checking bench for drv_imp_cal: vector table then directed corner tests.
module drv_imp_cal_bench;
    localparam int CW = 5;
    localparam int EV = 8;
    localparam int ST = 100;
    localparam int RC = 16;

    // {cmp[1:0], hiz, expected drv_code after the interval}
    localparam logic [7:0] VEC [0:9] = '{
        {2'b01, 1'b1, 5'd16},
        {2'b01, 1'b0, 5'd16},
        {2'b01, 1'b0, 5'd16},
        {2'b00, 1'b1, 5'd19},
        {2'b10, 1'b1, 5'd19},
        {2'b10, 1'b1, 5'd18},
        {2'b11, 1'b1, 5'd17},
        {2'b00, 1'b0, 5'd17},
        {2'b10, 1'b0, 5'd17},
        {2'b00, 1'b1, 5'd16}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    cmp = 2'b00;
    logic          hiz = 1'b1;
    logic [CW-1:0] code;
    logic          ready;
    int            n_chk = 0;
    int            n_fail = 0;

    always #2 clk = ~clk;

    drv_imp_cal #(.CODE_W(CW), .EVAL_PERIOD(EV), .SETTLE_CYCLES(ST), .RESET_CODE(RC))
        u_drv_imp_cal (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmp_i       (cmp),
        .hiz_i       (hiz),
        .drv_code_o  (code),
        .cal_ready_o (ready)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Reset for two edges with the given high-Z level; ends at a negedge
    task automatic do_reset(input logic hz);
        @(negedge clk);
        rst_n = 1'b0;
        cmp   = 2'b00;
        hiz   = hz;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R1 code in reset", int'(code), RC);
        check("R8 ready cleared by reset", int'(ready), 0);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        // Vector table: one evaluation interval per entry (R2, R3, R5, R6)
        do_reset(1'b1);
        for (int i = 0; i < 10; i++) begin
            cmp = VEC[i][7:6];
            hiz = VEC[i][5];
            repeat (EV) @(posedge clk);
            @(negedge clk);
            check($sformatf("R2/R5/R6 vector %0d", i), int'(code), int'(VEC[i][4:0]));
            check("R7 not ready before settle", int'(ready), 0);
        end

        // Evaluation edge timing and upper saturation
        do_reset(1'b1);
        check("R1 code after reset", int'(code), RC);
        cmp = 2'b01;
        repeat (EV - 1) @(posedge clk);
        @(negedge clk);
        check("R3 no step before interval", int'(code), RC);
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R3 single step after interval", int'(code), RC + 1);
        repeat (20 * EV) @(posedge clk);
        @(negedge clk);
        check("R4 saturate high", int'(code), 31);
        check("R7 high-Z held without transition", int'(ready), 0);
        hiz = 1'b0;
        @(posedge clk);
        @(negedge clk);
        hiz = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R7 ready on transition after settle", int'(ready), 1);
        hiz = 1'b0;
        repeat (5) @(posedge clk);
        @(negedge clk);
        check("R8 ready sticky", int'(ready), 1);
        check("R4 stays at max", int'(code), 31);

        // Lower saturation
        do_reset(1'b1);
        cmp = 2'b10;
        repeat (20 * EV) @(posedge clk);
        @(negedge clk);
        check("R4 saturate low", int'(code), 0);

        // Early transition ignored
        do_reset(1'b0);
        repeat (20) @(posedge clk);
        @(negedge clk);
        hiz = 1'b1;
        repeat (150) @(posedge clk);
        @(negedge clk);
        check("R7 early transition ignored", int'(ready), 0);
        hiz = 1'b0;
        @(posedge clk);
        @(negedge clk);
        hiz = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R7 later transition sets ready", int'(ready), 1);
        do_reset(1'b1);
        check("R1 ready low after reset", int'(ready), 0);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule